// File: doc/BRIEF.md
# Transmit Descriptor Sequence Validator

This block sits behind the descriptor fetch stage of a transmit DMA engine and inspects each 32-bit descriptor control word in fetch order. It only accepts a word whose ownership bit says the DMA holds it. While software still holds the presented word, the block keeps its ready output low and the fetch stage waits.

For every accepted word it tells a context descriptor from a normal one and keeps track of whether a packet is open. It catches three kinds of malformed descriptor: a word of all ones, a context word that also carries both the first and last flags, and a context word that turns up while a packet is still open. Exactly one cycle after each accepted word, it emits a close record. That record is the input word with ownership cleared and two status bits filled in: an error bit and a last-descriptor bit.

When an erroneous descriptor closes, the block marks the record as both erroneous and last, and it pulses a restart indication. The next normal descriptor then starts a fresh packet even if its first flag is clear. The block also pulses a transmit-interrupt request when a packet closes, normally or through an error, and the first descriptor of that packet asked for completion notice.

Top module: `txdesc_seq_check`

## Requirements
- R1: While `desc_valid` is high and bit 31 of `desc_word` is 0, `desc_ready` is low, and no close record follows.
- R2: A descriptor is accepted when `desc_valid`, `desc_ready` and bit 31 are all high. In the next cycle `wb_valid` pulses for one cycle. `wb_word` then equals the input word with bit 31 cleared, and all bits other than 31, 28 and 23 are unchanged.
- R3: A word equal to 0xFFFFFFFF closes with error bit 23 set and last bit 28 set.
- R4: A context word (bit 30 = 1) presented with both `first_flag` and `last_flag` high closes with bits 23 and 28 set.
- R5: A context word accepted while a packet is open (a normal descriptor has started the packet and no last descriptor has closed it yet) closes with bits 23 and 28 set.
- R6: A context word accepted while no packet is open, without first+last, closes with bits 23 and 28 clear.
- R7: An error-free normal word (bit 30 = 0) closes with bit 23 clear and bit 28 equal to `last_flag`.
- R8: An erroneous close pulses `tx_irq` together with `wb_valid` exactly when the packet's first descriptor carried `ioc_flag`. The packet's first descriptor is the descriptor itself when no packet is open.
- R9: An erroneous close pulses `pkt_restart` and ends the open packet. The next normal descriptor starts a new packet even with `first_flag` low, and that descriptor's `ioc_flag` is the one that counts for the new packet.
- R10: An error-free normal close with `last_flag` high pulses `tx_irq` when the packet's first descriptor carried `ioc_flag`.
- R11: After reset, no packet is open and `wb_valid`, `tx_irq` and `pkt_restart` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | A descriptor word is presented |
| desc_word | input | 32 | Descriptor control word |
| first_flag | input | 1 | Descriptor is marked as first of a packet |
| last_flag | input | 1 | Descriptor is marked as last of a packet |
| ioc_flag | input | 1 | Completion interrupt requested for the packet |
| desc_ready | output | 1 | Block can accept the presented word |
| wb_valid | output | 1 | Close record valid (one-cycle pulse) |
| wb_word | output | 32 | Close record word |
| tx_irq | output | 1 | Transmit-interrupt request pulse |
| pkt_restart | output | 1 | Next descriptor will start a new packet |

## Verification
An erroneous close and the transmit-interrupt request can land in the same cycle. This happens when a context word arrives inside a packet whose first descriptor asked for completion notice, or when a context word carrying first and last arrives with `ioc_flag` high. The scoreboard predicts the record word, the interrupt and the restart together for each accepted word, and compares all three in the one cycle when `wb_valid` rises. The same error is also provoked with completion notice off, so an interrupt that fires on every error is caught.

// File: rtl/txd_pkg.sv
package txd_pkg;
    localparam int DW       = 32;
    localparam int OWN_BIT  = 31;
    localparam int CTX_BIT  = 30;
    localparam int LAST_BIT = 28;
    localparam int ERR_BIT  = 23;

    typedef struct packed {
        logic          ctx;
        logic          all_ones;
        logic          first;
        logic          last;
        logic          ioc;
        logic [DW-1:0] word;
    } desc_t;

    typedef struct packed {
        logic err;
        logic closes_pkt;
        logic irq;
    } verdict_t;

    function automatic logic [DW-1:0] make_record(input logic [DW-1:0] w,
                                                   input logic err,
                                                   input logic last);
        logic [DW-1:0] r;
        r = w;
        r[OWN_BIT]  = 1'b0;
        r[ERR_BIT]  = err;
        r[LAST_BIT] = last;
        return r;
    endfunction
endpackage

// File: rtl/txd_decode.sv
module txd_decode
    import txd_pkg::*;
(
    input  logic [DW-1:0] word,
    input  logic          first_flag,
    input  logic          last_flag,
    input  logic          ioc_flag,
    output desc_t         desc
);
    always_comb begin
        desc.word     = word;
        desc.ctx      = word[CTX_BIT];
        desc.all_ones = &word;
        desc.first    = first_flag;
        desc.last     = last_flag;
        desc.ioc      = ioc_flag;
    end
endmodule

// File: rtl/txd_sequencer.sv
module txd_sequencer
    import txd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     accept,
    input  desc_t    desc,
    output verdict_t verdict
);
    logic pkt_open;
    logic ioc_held;
    logic starts_pkt;
    logic ioc_eff;

    always_comb begin
        // A normal word starts a packet if flagged first or if none is open
        starts_pkt = !desc.ctx && (desc.first || !pkt_open);
        ioc_eff    = (pkt_open && !starts_pkt) ? ioc_held : desc.ioc;
        verdict.err = desc.all_ones
                    || (desc.ctx && desc.first && desc.last)
                    || (desc.ctx && pkt_open);
        verdict.closes_pkt = verdict.err || (!desc.ctx && desc.last);
        verdict.irq = verdict.closes_pkt && ioc_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_open <= 1'b0;
            ioc_held <= 1'b0;
        end else if (accept) begin
            if (verdict.err) begin
                pkt_open <= 1'b0;
            end else if (!desc.ctx) begin
                if (starts_pkt) ioc_held <= desc.ioc;
                pkt_open <= !desc.last;
            end
        end
    end
endmodule

// File: rtl/txd_wb_reg.sv
module txd_wb_reg
    import txd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  desc_t         desc,
    input  verdict_t      verdict,
    output logic          wb_valid,
    output logic [DW-1:0] wb_word,
    output logic          tx_irq,
    output logic          pkt_restart
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid    <= 1'b0;
            wb_word     <= '0;
            tx_irq      <= 1'b0;
            pkt_restart <= 1'b0;
        end else begin
            wb_valid    <= accept;
            tx_irq      <= accept && verdict.irq;
            pkt_restart <= accept && verdict.err;
            if (accept) begin
                wb_word <= make_record(desc.word, verdict.err,
                                       verdict.closes_pkt);
            end
        end
    end
endmodule

// File: rtl/txdesc_seq_check.sv
module txdesc_seq_check
    import txd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          desc_valid,
    input  logic [DW-1:0] desc_word,
    input  logic          first_flag,
    input  logic          last_flag,
    input  logic          ioc_flag,
    output logic          desc_ready,
    output logic          wb_valid,
    output logic [DW-1:0] wb_word,
    output logic          tx_irq,
    output logic          pkt_restart
);
    desc_t    desc;
    verdict_t verdict;
    logic     accept;

    // Stall while software still holds the presented word
    assign desc_ready = !desc_valid || desc_word[OWN_BIT];
    assign accept     = desc_valid && desc_word[OWN_BIT];

    txd_decode u_decode (
        .word       (desc_word),
        .first_flag (first_flag),
        .last_flag  (last_flag),
        .ioc_flag   (ioc_flag),
        .desc       (desc)
    );

    txd_sequencer u_seq (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .desc    (desc),
        .verdict (verdict)
    );

    txd_wb_reg u_wb (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .desc        (desc),
        .verdict     (verdict),
        .wb_valid    (wb_valid),
        .wb_word     (wb_word),
        .tx_irq      (tx_irq),
        .pkt_restart (pkt_restart)
    );
endmodule

// File: rtl/txdesc_seq_check_sva.sv
module txdesc_seq_check_sva
    import txd_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          desc_valid,
    input logic [DW-1:0] desc_word,
    input logic          first_flag,
    input logic          last_flag,
    input logic          desc_ready,
    input logic          wb_valid,
    input logic [DW-1:0] wb_word,
    input logic          tx_irq,
    input logic          pkt_restart
);
    assert_unowned_no_record_R1: assert property (@(posedge clk) disable iff (rst)
        (desc_valid && !desc_word[OWN_BIT]) |=> !wb_valid);

    assert_record_next_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        (desc_valid && desc_ready && desc_word[OWN_BIT]) |=> wb_valid);

    assert_own_cleared_R2: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> !wb_word[OWN_BIT]);

    assert_all_ones_error_R3: assert property (@(posedge clk) disable iff (rst)
        (desc_valid && (&desc_word)) |=> (wb_word[ERR_BIT] && wb_word[LAST_BIT]));

    assert_ctx_fl_error_R4: assert property (@(posedge clk) disable iff (rst)
        (desc_valid && desc_word[OWN_BIT] && desc_word[CTX_BIT] && first_flag && last_flag)
        |=> wb_word[ERR_BIT]);

    assert_error_is_last_R8: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && wb_word[ERR_BIT]) |-> wb_word[LAST_BIT]);

    assert_irq_with_record_R10: assert property (@(posedge clk) disable iff (rst)
        tx_irq |-> (wb_valid && wb_word[LAST_BIT]));

    assert_restart_on_error_R9: assert property (@(posedge clk) disable iff (rst)
        pkt_restart |-> (wb_valid && wb_word[ERR_BIT]));

    assert_no_idle_record_R2: assert property (@(posedge clk) disable iff (rst)
        !desc_valid |=> !wb_valid);
endmodule

bind txdesc_seq_check txdesc_seq_check_sva u_sva (
    .clk         (clk),
    .rst         (rst),
    .desc_valid  (desc_valid),
    .desc_word   (desc_word),
    .first_flag  (first_flag),
    .last_flag   (last_flag),
    .desc_ready  (desc_ready),
    .wb_valid    (wb_valid),
    .wb_word     (wb_word),
    .tx_irq      (tx_irq),
    .pkt_restart (pkt_restart)
);

// File: tb/txdesc_seq_check_bench.sv
module txdesc_seq_check_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        desc_valid = 1'b0;
    logic [31:0] desc_word = '0;
    logic        first_flag = 1'b0;
    logic        last_flag = 1'b0;
    logic        ioc_flag = 1'b0;
    logic        desc_ready;
    logic        wb_valid;
    logic [31:0] wb_word;
    logic        tx_irq;
    logic        pkt_restart;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] word;
        logic        irq;
        logic        restart;
        string       tag;
    } exp_t;

    exp_t sb[$];

    // Bench model state, built from the requirements
    bit m_open = 1'b0;
    bit m_ioc  = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    txdesc_seq_check u_txdesc_seq_check (
        .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_word(desc_word),
        .first_flag(first_flag), .last_flag(last_flag), .ioc_flag(ioc_flag),
        .desc_ready(desc_ready), .wb_valid(wb_valid), .wb_word(wb_word),
        .tx_irq(tx_irq), .pkt_restart(pkt_restart)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: present one owned descriptor for one cycle, push expectation
    task automatic send(input logic [31:0] w, input bit f, input bit l,
                        input bit ioc, input string tag);
        exp_t e;
        bit ctx, err, start, ioce, closes;
        ctx    = w[30];
        err    = (w == 32'hFFFF_FFFF) || (ctx && f && l) || (ctx && m_open);
        start  = !ctx && (f || !m_open);
        ioce   = (m_open && !start) ? m_ioc : ioc;
        closes = err || (!ctx && l);
        e.word = w;
        e.word[31] = 1'b0;
        e.word[23] = err;
        e.word[28] = closes;
        e.irq = closes && ioce;
        e.restart = err;
        e.tag = tag;
        if (err) m_open = 1'b0;
        else if (!ctx) begin
            if (start) m_ioc = ioc;
            m_open = !l;
        end
        sb.push_back(e);
        @(negedge clk);
        desc_valid = 1'b1; desc_word = w;
        first_flag = f; last_flag = l; ioc_flag = ioc;
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        desc_valid = 1'b0; first_flag = 1'b0; last_flag = 1'b0; ioc_flag = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare each record against the queue
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && wb_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2 unexpected record", {32'h0, wb_word}, 64'h0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(wb_word == e.word, {e.tag, " word"}, {32'h0, wb_word}, {32'h0, e.word});
                    check(tx_irq == e.irq, {e.tag, " irq"}, {63'h0, tx_irq}, {63'h0, e.irq});
                    check(pkt_restart == e.restart, {e.tag, " restart"},
                          {63'h0, pkt_restart}, {63'h0, e.restart});
                end
            end else if (!rst) begin
                if (tx_irq || pkt_restart)
                    check(1'b0, "R2 pulse without record", {62'h0, tx_irq, pkt_restart}, 64'h0);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        check(!wb_valid && !tx_irq && !pkt_restart, "R11 reset outputs",
              {61'h0, wb_valid, tx_irq, pkt_restart}, 64'h0);
        check(desc_ready, "R11 ready idle", {63'h0, desc_ready}, 64'h1);

        // R1: software-owned word stalls
        desc_valid = 1'b1; desc_word = 32'h0000_1234; first_flag = 1'b1; last_flag = 1'b1;
        #1 check(!desc_ready, "R1 ready low for unowned", {63'h0, desc_ready}, 64'h0);
        repeat (3) @(negedge clk);
        check(!wb_valid, "R1 no record for unowned", {63'h0, wb_valid}, 64'h0);
        idle(1);

        // R7/R10: single-descriptor packet with completion notice
        send(32'h8001_0055, 1, 1, 1, "R7 R10 single packet");
        // R6: context between packets
        send(32'hC000_ABCD, 0, 0, 0, "R6 context between packets");
        // R2: pass-through of a busy pattern, packet opens
        send(32'h8F7F_FFFE, 1, 0, 1, "R2 pass-through first");
        send(32'h8000_0002, 0, 0, 0, "R7 middle");
        // R5 + R8: context inside open packet whose first had ioc
        send(32'hC000_0003, 0, 0, 0, "R5 R8 context in packet");
        // R9: next normal word starts a packet though first flag is clear
        send(32'h8000_0010, 0, 1, 0, "R9 implicit first no ioc");
        send(32'h8000_0011, 0, 1, 1, "R9 R10 implicit first ioc");
        idle(2);
        // R3 with no completion notice: error without irq (R8)
        send(32'hFFFF_FFFF, 0, 0, 0, "R3 R8 all ones no ioc");
        // R4 with completion notice on the same word
        send(32'hC000_0000, 1, 1, 1, "R4 R8 context first last");
        // R3 inside a packet whose first had no ioc
        send(32'h8000_0020, 1, 0, 0, "R7 first no ioc");
        send(32'hFFFF_FFFF, 1, 1, 1, "R3 R8 all ones in packet");
        // R5 with ioc off on the packet
        send(32'h8000_0030, 1, 0, 0, "R7 first");
        send(32'hC000_0031, 0, 0, 1, "R5 context in packet no ioc");
        send(32'h8000_0032, 1, 0, 1, "R9 after error");
        send(32'h8000_0033, 0, 1, 0, "R10 last uses first ioc");
        idle(4);
        check(sb.size() == 0, "R2 all records seen", {32'h0, 32'(sb.size())}, 64'h0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule